// File: doc/BRIEF.md
# UART XON/XOFF Flow Control Engine

This block adds in-band software flow control to a UART. It sits between the receive deserialiser and the receive FIFO, and between the transmit FIFO and the transmit serialiser. It holds four programmable characters: two "resume" characters (ON1, ON2) and two "pause" characters (OFF1, OFF2). A 4-bit mode field picks how they are used. The receive path inspects every incoming byte. A pause character stops the local transmitter at the next byte boundary, and a resume character lets it run again. Flow-control bytes are swallowed and never reach the FIFO. On the transmit side, the receive-FIFO fill level drives the block: when the FIFO fills past a high mark, a pause sequence is inserted ahead of the next data byte. When the FIFO drains to a low mark, a resume sequence is inserted.

Each pair of characters can be used on its own, or the two pairs can form two-byte sequences (ON1 then ON2, OFF1 then OFF2). A separate detect mode flags a chosen character while still delivering it as data. A protected 8-bit field holds upper enhanced control bits for neighbouring registers. It can only be written while an unlock bit is set.

Configuration uses a small write port. Selector 0 writes ON1, 1 writes ON2, 2 writes OFF1, 3 writes OFF2. Selector 4 writes the control byte: bits [3:0] are the mode field, bit 4 is the unlock bit and bit 5 enables detect. Selector 5 writes the protected field. Selector 6 with data bit 0 set clears the detect flag.

Top module: `uart_swflow`

## Requirements
- R1: After reset, all characters, the control byte, the protected field and the detect flag are 0, the transmitter is not stopped, and with mode 0 every received byte is delivered as data.
- R2: Mode bits [3:2] select the inserted characters: 2'b10 uses ON1/OFF1, 2'b01 uses ON2/OFF2, 2'b11 sends two bytes (ON1 then ON2, or OFF1 then OFF2), and 2'b00 inserts nothing.
- R3: With insertion enabled, a pause sequence is sent once when `rxf_level` reaches `HI_LVL` or more. After that, a resume sequence is sent once when the level is `LO_LVL` or less. No other level causes a repeat.
- R4: A byte is only loaded when `ser_ready` is 1. A pending inserted byte wins over FIFO data, and `txq_pop` is only raised together with a data load.
- R5: Mode bits [1:0] = 2'b10 (pair 1) or 2'b01 (pair 2) make the matching pause character stop data loads and the matching resume character restart them. Matched characters are not delivered.
- R6: Mode bits [1:0] = 2'b11 with bits [3:2] non-zero act on two consecutive bytes: OFF1 then OFF2 stops, ON1 then ON2 resumes, and neither byte is delivered.
- R7: In two-byte mode, if a first byte (ON1 or OFF1) is followed by any byte other than its partner, the first byte is delivered as data. The second byte is then judged afresh.
- R8: Receive code 2'b11 with transmit code 2'b00 behaves as no receive flow control.
- R9: Writing a control byte whose receive code is effectively off clears the stopped state from the edge that takes the write.
- R10: With detect enabled and mode field 0, a received byte equal to OFF2 is delivered and sets `spc_flag` in the same cycle. With a non-zero mode field, detect does nothing.
- R11: `spc_flag` stays set until a write to selector 6 with data bit 0 = 1.
- R12: `enh_q` takes a selector-5 write only while the unlock bit (control bit 4) is 1; otherwise it keeps its value.
- R13: A delivered byte appears on `rxf_valid`/`rxf_byte` one cycle after it is presented. Received bytes must be spaced at least two idle cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration selector |
| cfg_wdata | input | DW | Configuration write data |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | DW | Received byte |
| rxf_valid | output | 1 | Byte delivered to receive FIFO |
| rxf_byte | output | DW | Delivered byte |
| spc_flag | output | 1 | Detect flag |
| rxf_level | input | LW | Receive FIFO fill level |
| txq_valid | input | 1 | Transmit FIFO has data |
| txq_byte | input | DW | Transmit FIFO head byte |
| txq_pop | output | 1 | Consume transmit FIFO head |
| ser_ready | input | 1 | Serialiser can accept a byte |
| ser_load | output | 1 | Load byte into serialiser |
| ser_byte | output | DW | Byte to serialiser |
| tx_stopped | output | 1 | Data transmission paused by remote |
| enh_q | output | DW | Protected enhanced control field |

## Verification
The receive matcher is driven with each single-pair code, with the both-pairs code, and with that code while the transmit code is zero. Each code gets matching characters, characters of the other pair and plain data, which separates correct pair selection from over-eager matching. Broken two-byte sequences are tested too: a lone first byte, and a first byte followed by the other pair's first byte. These show whether the held byte is released in order and the following byte is re-judged. Fill-level ramps through the marks, past them and back are run under a stalling serialiser for all three transmit codes. This checks the once-only insertion, the byte order of the two-byte forms, and that insertion never overtakes an occupied serialiser.

// File: rtl/uart_swflow.sv
module uart_swflow #(
  parameter int DW     = 8,
  parameter int LW     = 5,
  parameter int HI_LVL = 12,
  parameter int LO_LVL = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [DW-1:0] cfg_wdata,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_byte,
  output logic          rxf_valid,
  output logic [DW-1:0] rxf_byte,
  output logic          spc_flag,
  input  logic [LW-1:0] rxf_level,
  input  logic          txq_valid,
  input  logic [DW-1:0] txq_byte,
  output logic          txq_pop,
  input  logic          ser_ready,
  output logic          ser_load,
  output logic [DW-1:0] ser_byte,
  output logic          tx_stopped,
  output logic [DW-1:0] enh_q
);
  typedef enum logic [1:0] {ARM_NONE, ARM_ON, ARM_OFF} arm_t;

  logic [DW-1:0] on1, on2, off1, off2;
  logic [3:0]    mode;
  logic          unlock, det_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      on1 <= '0; on2 <= '0; off1 <= '0; off2 <= '0;
      mode <= '0; unlock <= 1'b0; det_en <= 1'b0; enh_q <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        3'd0: on1  <= cfg_wdata;
        3'd1: on2  <= cfg_wdata;
        3'd2: off1 <= cfg_wdata;
        3'd3: off2 <= cfg_wdata;
        3'd4: begin
          mode   <= cfg_wdata[3:0];
          unlock <= cfg_wdata[4];
          det_en <= cfg_wdata[5];
        end
        3'd5: if (unlock) enh_q <= cfg_wdata;
        default: ;
      endcase
    end
  end

  wire [1:0] tm = mode[3:2];
  wire [1:0] rm = (mode[1:0] == 2'b11 && tm == 2'b00) ? 2'b00 : mode[1:0];

  logic          rep_v;
  logic [DW-1:0] rep_b, held;
  arm_t          arm, arm_n;
  logic          stop;
  logic          pass, flush, ev_on, ev_off;

  wire          in_v = rx_valid | rep_v;
  wire [DW-1:0] in_b = rep_v ? rep_b : rx_byte;
  wire          det_hit = in_v && det_en && mode == 4'd0 && in_b == off2;

  always_comb begin
    pass = 1'b0; flush = 1'b0; ev_on = 1'b0; ev_off = 1'b0;
    arm_n = (rm == 2'b11) ? arm : ARM_NONE;
    if (in_v) begin
      case (rm)
        2'b10: begin
          if (in_b == off1)     ev_off = 1'b1;
          else if (in_b == on1) ev_on  = 1'b1;
          else                  pass   = 1'b1;
        end
        2'b01: begin
          if (in_b == off2)     ev_off = 1'b1;
          else if (in_b == on2) ev_on  = 1'b1;
          else                  pass   = 1'b1;
        end
        2'b11: begin
          case (arm)
            ARM_NONE: begin
              if (in_b == off1)     arm_n = ARM_OFF;
              else if (in_b == on1) arm_n = ARM_ON;
              else                  pass  = 1'b1;
            end
            ARM_ON: begin
              arm_n = ARM_NONE;
              if (in_b == on2) ev_on = 1'b1;
              else             flush = 1'b1;
            end
            default: begin
              arm_n = ARM_NONE;
              if (in_b == off2) ev_off = 1'b1;
              else              flush  = 1'b1;
            end
          endcase
        end
        default: pass = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxf_valid <= 1'b0; rxf_byte <= '0; rep_v <= 1'b0; rep_b <= '0;
      held <= '0; arm <= ARM_NONE; stop <= 1'b0; spc_flag <= 1'b0;
    end else begin
      rxf_valid <= pass | flush;
      if (pass | flush) rxf_byte <= flush ? held : in_b;
      rep_v <= flush;
      rep_b <= in_b;
      arm   <= arm_n;
      if (arm == ARM_NONE && arm_n != ARM_NONE) held <= in_b;
      if (rm == 2'b00) stop <= 1'b0;
      else if (ev_off) stop <= 1'b1;
      else if (ev_on)  stop <= 1'b0;
      if (det_hit) spc_flag <= 1'b1;
      else if (cfg_we && cfg_sel == 3'd6 && cfg_wdata[0]) spc_flag <= 1'b0;
    end
  end

  assign tx_stopped = stop & (rm != 2'b00);

  logic [1:0]    ins_cnt;
  logic [DW-1:0] seq0, seq1;
  logic          sent_off;
  wire           two = (tm == 2'b11);

  always_ff @(posedge clk) begin
    if (!rst_n || tm == 2'b00) begin
      ins_cnt <= '0; sent_off <= 1'b0; seq0 <= '0; seq1 <= '0;
    end else if (ins_cnt != 2'd0) begin
      if (ser_ready) ins_cnt <= ins_cnt - 2'd1;
    end else if (!sent_off && rxf_level >= LW'(HI_LVL)) begin
      ins_cnt  <= two ? 2'd2 : 2'd1;
      seq0     <= off1;
      seq1     <= (two || tm == 2'b01) ? off2 : off1;
      sent_off <= 1'b1;
    end else if (sent_off && rxf_level <= LW'(LO_LVL)) begin
      ins_cnt  <= two ? 2'd2 : 2'd1;
      seq0     <= on1;
      seq1     <= (two || tm == 2'b01) ? on2 : on1;
      sent_off <= 1'b0;
    end
  end

  wire ins_busy = (ins_cnt != 2'd0);
  assign txq_pop  = ser_ready & ~ins_busy & ~tx_stopped & txq_valid;
  assign ser_load = ser_ready & (ins_busy | (~tx_stopped & txq_valid));
  assign ser_byte = ins_busy ? ((ins_cnt == 2'd2) ? seq0 : seq1) : txq_byte;
endmodule

module uart_swflow_chk #(parameter int DW = 8) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic [2:0]    cfg_sel,
  input logic          rx_valid,
  input logic          rxf_valid,
  input logic          spc_flag,
  input logic          txq_pop,
  input logic          ser_ready,
  input logic          ser_load,
  input logic          tx_stopped,
  input logic [DW-1:0] enh_q
);
  assert_pop_with_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    txq_pop |-> ser_load);
  assert_load_needs_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ser_load |-> ser_ready);
  assert_stopped_no_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_stopped |-> !txq_pop);
  assert_stop_follows_rx_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_stopped) |-> $past(rx_valid));
  assert_flag_with_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spc_flag) |-> rxf_valid);
  assert_flag_clear_by_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spc_flag) |-> $past(cfg_we && cfg_sel == 3'd6));
  assert_enh_only_by_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(enh_q) |-> $past(cfg_we && cfg_sel == 3'd5));
endmodule

bind uart_swflow uart_swflow_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
  .rx_valid(rx_valid), .rxf_valid(rxf_valid), .spc_flag(spc_flag),
  .txq_pop(txq_pop), .ser_ready(ser_ready), .ser_load(ser_load),
  .tx_stopped(tx_stopped), .enh_q(enh_q)
);

// File: tb/uart_swflow_tb.sv
module uart_swflow_tb;
  localparam int DW = 8, LW = 5, HI = 12, LO = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, cfg_we = 1'b0, rx_valid = 1'b0, txq_valid = 1'b0, ser_ready = 1'b1;
  logic [2:0] cfg_sel = '0;
  logic [DW-1:0] cfg_wdata = '0, rx_byte = '0, txq_byte = 8'h80;
  logic [LW-1:0] rxf_level = '0;
  logic rxf_valid, spc_flag, txq_pop, ser_load, tx_stopped;
  logic [DW-1:0] rxf_byte, ser_byte, enh_q;

  uart_swflow #(.DW(DW), .LW(LW), .HI_LVL(HI), .LO_LVL(LO)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rxf_valid(rxf_valid), .rxf_byte(rxf_byte),
    .spc_flag(spc_flag), .rxf_level(rxf_level), .txq_valid(txq_valid), .txq_byte(txq_byte),
    .txq_pop(txq_pop), .ser_ready(ser_ready), .ser_load(ser_load), .ser_byte(ser_byte),
    .tx_stopped(tx_stopped), .enh_q(enh_q));

  int n_tests = 0, n_fail = 0, cyc = 0;
  bit done = 0, stall_pat = 0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model state
  logic [7:0] m_ch[4];
  logic [3:0] m_mode;
  bit m_det, m_unl, m_flag, m_stop, m_repv, e_rxv, m_sent;
  logic [7:0] m_enh, m_held, m_repb, e_rxb;
  int m_arm;
  logic [7:0] ins_q[$];
  logic [7:0] rxlog[$], inslog[$];
  int t_rm, t_tm;
  bit t_hv, t_on, t_off, t_nv, t_nrep;
  logic [7:0] t_b, t_nb;

  function automatic int eff_rm();
    return (m_mode[1:0] == 2'b11 && m_mode[3:2] == 2'b00) ? 0 : int'(m_mode[1:0]);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_ch[i]) m_ch[i] = '0;
      m_mode = '0; m_det = 0; m_unl = 0; m_flag = 0; m_stop = 0; m_repv = 0;
      e_rxv = 0; m_sent = 0; m_enh = '0; m_held = '0; m_repb = '0; e_rxb = '0;
      m_arm = 0; ins_q.delete();
    end else begin
      t_rm = eff_rm(); t_tm = int'(m_mode[3:2]);
      t_hv = rx_valid || m_repv; t_b = m_repv ? m_repb : rx_byte;
      t_on = 0; t_off = 0; t_nv = 0; t_nrep = 0; t_nb = e_rxb;
      if (t_hv) begin
        if (t_rm == 2 || t_rm == 1) begin
          if (t_b == m_ch[t_rm == 2 ? 2 : 3]) t_off = 1;
          else if (t_b == m_ch[t_rm == 2 ? 0 : 1]) t_on = 1;
          else begin t_nv = 1; t_nb = t_b; end
        end else if (t_rm == 3) begin
          if (m_arm == 0) begin
            if (t_b == m_ch[2]) begin m_arm = 2; m_held = t_b; end
            else if (t_b == m_ch[0]) begin m_arm = 1; m_held = t_b; end
            else begin t_nv = 1; t_nb = t_b; end
          end else begin
            if (t_b == m_ch[m_arm == 1 ? 1 : 3]) begin
              if (m_arm == 1) t_on = 1; else t_off = 1;
            end else begin t_nv = 1; t_nb = m_held; t_nrep = 1; end
            m_arm = 0;
          end
        end else begin t_nv = 1; t_nb = t_b; end
      end
      if (t_rm != 3) m_arm = 0;
      if (t_hv && m_det && m_mode == 0 && t_b == m_ch[3]) m_flag = 1;
      else if (cfg_we && cfg_sel == 6 && cfg_wdata[0]) m_flag = 0;
      m_repv = t_nrep; m_repb = t_b;
      e_rxv = t_nv; e_rxb = t_nb;
      if (t_rm == 0) m_stop = 0; else if (t_off) m_stop = 1; else if (t_on) m_stop = 0;
      if (t_tm == 0) begin ins_q.delete(); m_sent = 0; end
      else if (ins_q.size() > 0) begin if (ser_ready) void'(ins_q.pop_front()); end
      else if (!m_sent && rxf_level >= HI) begin
        m_sent = 1;
        if (t_tm == 3) begin ins_q.push_back(m_ch[2]); ins_q.push_back(m_ch[3]); end
        else ins_q.push_back(m_ch[t_tm == 2 ? 2 : 3]);
      end else if (m_sent && rxf_level <= LO) begin
        m_sent = 0;
        if (t_tm == 3) begin ins_q.push_back(m_ch[0]); ins_q.push_back(m_ch[1]); end
        else ins_q.push_back(m_ch[t_tm == 2 ? 0 : 1]);
      end
      if (cfg_we) begin
        if (cfg_sel < 4) m_ch[cfg_sel[1:0]] = cfg_wdata;
        else if (cfg_sel == 4) begin
          m_mode = cfg_wdata[3:0]; m_unl = cfg_wdata[4]; m_det = cfg_wdata[5];
        end else if (cfg_sel == 5 && m_unl) m_enh = cfg_wdata;
      end
    end
  end

  // per-cycle comparison against the model
  bit e_stop, e_load, e_pop;
  always @(negedge clk) if (rst_n && !done) begin
    e_stop = m_stop && eff_rm() != 0;
    e_load = ser_ready && (ins_q.size() > 0 || (!e_stop && txq_valid));
    e_pop  = ser_ready && ins_q.size() == 0 && !e_stop && txq_valid;
    check("R13 rxf_valid", rxf_valid, e_rxv);
    if (e_rxv) check("R13 rxf_byte", rxf_byte, e_rxb);
    check("R5 tx_stopped", tx_stopped, e_stop);
    check("R10 spc_flag", spc_flag, m_flag);
    check("R12 enh_q", enh_q, m_enh);
    check("R4 ser_load", ser_load, e_load);
    check("R4 txq_pop", txq_pop, e_pop);
    if (e_load) check("R4 ser_byte", ser_byte, ins_q.size() > 0 ? ins_q[0] : txq_byte);
    if (rxf_valid) rxlog.push_back(rxf_byte);
    if (ser_load && !txq_pop) inslog.push_back(ser_byte);
  end

  // transmit FIFO and serialiser stand-ins
  initial begin
    bit p;
    forever begin
      @(negedge clk); p = txq_pop;
      @(posedge clk); #1;
      if (p) txq_byte = txq_byte + 8'd1;
      ser_ready = stall_pat ? ((cyc % 3) != 0) : 1'b1;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1; n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    @(posedge clk); #1; cfg_we = 1; cfg_sel = s; cfg_wdata = d;
    @(posedge clk); #1; cfg_we = 0;
  endtask

  task automatic rx(input logic [7:0] b);
    @(posedge clk); #1; rx_valid = 1; rx_byte = b;
    @(posedge clk); #1; rx_valid = 0;
    repeat (3) @(posedge clk);
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic lvl(input logic [LW-1:0] v);
    @(posedge clk); #1; rxf_level = v;
    repeat (12) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk); #1; rst_n = 1;
    @(negedge clk);
    check("R1 reset tx_stopped", tx_stopped, 0);
    check("R1 reset spc_flag", spc_flag, 0);
    check("R1 reset enh_q", enh_q, 0);
    check("R1 reset rxf_valid", rxf_valid, 0);
    check("R1 reset ser_load", ser_load, 0);

    wr(0, 8'h11); wr(1, 8'h12); wr(2, 8'h13); wr(3, 8'h14);
    rxlog.delete();
    rx(8'h41); rx(8'h13); settle(1);
    check("R1 mode0 passes count", rxlog.size(), 2);
    check("R1 mode0 passes flow char", rxlog[1], 8'h13);

    txq_valid = 1;
    wr(4, 8'h02); rxlog.delete();
    rx(8'h13); settle(1);
    check("R5 pair1 pause", tx_stopped, 1);
    check("R5 no pop while stopped", txq_pop, 0);
    rx(8'h55); rx(8'h11); settle(1);
    check("R5 pair1 resume", tx_stopped, 0);
    check("R5 only data delivered", rxlog.size(), 1);
    wr(4, 8'h01); rxlog.delete();
    rx(8'h14); settle(1);
    check("R5 pair2 pause", tx_stopped, 1);
    rx(8'h13); rx(8'h12); settle(1);
    check("R5 pair2 resume", tx_stopped, 0);
    check("R5 other pair is data", rxlog.size() == 1 && rxlog[0] == 8'h13, 1);

    wr(4, 8'h03); rxlog.delete();
    rx(8'h13); settle(1);
    check("R8 code11 tx off no stop", tx_stopped, 0);
    check("R8 code11 tx off delivers", rxlog.size(), 1);

    wr(4, 8'h0B); rxlog.delete();
    rx(8'h13); settle(1);
    check("R6 first byte alone no stop", tx_stopped, 0);
    rx(8'h14); settle(1);
    check("R6 pair sequence stops", tx_stopped, 1);
    rx(8'h11); rx(8'h12); settle(1);
    check("R6 resume sequence", tx_stopped, 0);
    check("R6 nothing delivered", rxlog.size(), 0);
    rx(8'h11); rx(8'h55); settle(1);
    check("R7 broken count", rxlog.size(), 2);
    check("R7 held byte first", rxlog.size() == 2 && rxlog[0] == 8'h11 && rxlog[1] == 8'h55, 1);
    rx(8'h13); rx(8'h14); rxlog.delete();
    rx(8'h13); rx(8'h11); rx(8'h12); settle(1);
    check("R7 re-judged byte resumes", tx_stopped, 0);
    check("R7 released off byte", rxlog.size() == 1 && rxlog[0] == 8'h13, 1);

    rx(8'h13); rx(8'h14); settle(1);
    check("R9 stopped before disable", tx_stopped, 1);
    wr(4, 8'h08); @(negedge clk);
    check("R9 disable clears stop", tx_stopped, 0);

    stall_pat = 1; inslog.delete();
    lvl(8);
    check("R3 below high no insert", inslog.size(), 0);
    lvl(12);
    check("R3 pause once", inslog.size(), 1);
    check("R2 code10 pause char", inslog[0], 8'h13);
    lvl(15); lvl(5);
    check("R3 no repeat", inslog.size(), 1);
    lvl(4);
    check("R2 code10 resume char", inslog.size() == 2 && inslog[1] == 8'h11, 1);
    wr(4, 8'h04); inslog.delete();
    lvl(13); lvl(2);
    check("R2 code01 chars", inslog.size() == 2 && inslog[0] == 8'h14 && inslog[1] == 8'h12, 1);
    wr(4, 8'h0C); inslog.delete();
    lvl(20);
    check("R2 code11 pause seq", inslog.size() == 2 && inslog[0] == 8'h13 && inslog[1] == 8'h14, 1);
    lvl(0);
    check("R2 code11 resume seq", inslog.size() == 4 && inslog[2] == 8'h11 && inslog[3] == 8'h12, 1);
    stall_pat = 0;
    wr(4, 8'h00); inslog.delete();
    lvl(25);
    check("R2 code00 no insert", inslog.size(), 0);
    txq_valid = 0;

    wr(4, 8'h20); rxlog.delete();
    rx(8'h14); settle(1);
    check("R10 detect flag", spc_flag, 1);
    check("R10 byte kept", rxlog.size() == 1 && rxlog[0] == 8'h14, 1);
    settle(3);
    check("R11 flag holds", spc_flag, 1);
    wr(6, 8'h00); settle(1);
    check("R11 zero write keeps", spc_flag, 1);
    wr(6, 8'h01); settle(1);
    check("R11 clear", spc_flag, 0);
    wr(4, 8'h22); rxlog.delete();
    rx(8'h14); settle(1);
    check("R10 inactive with mode", spc_flag, 0);
    check("R10 byte delivered", rxlog.size(), 1);

    wr(4, 8'h00); wr(5, 8'hAA); settle(1);
    check("R12 locked write ignored", enh_q, 8'h00);
    wr(4, 8'h10); wr(5, 8'h5A); settle(1);
    check("R12 unlocked write", enh_q, 8'h5A);
    wr(4, 8'h00); wr(5, 8'hFF); settle(1);
    check("R12 relocked keeps", enh_q, 8'h5A);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule